// File: doc/BRIEF.md
# Exception Return Legality Checker

This block judges a request to leave an exception handler and resume at a lower or equal privilege level. From the saved status word, the current level, the saved return address and a handful of configuration bits, it works out which level is being asked for. It then runs an ordered set of legality rules and forms the program counter and status word to resume with. A request is a one-cycle strobe. The verdict and results are registered and appear on the following cycle together with a one-cycle done pulse.

A legal return adopts the saved status word and aligns the return address to the requested instruction width. An illegal return does not fault. Execution stays at the current level and current status. Only the condition flags and interrupt masks come from the saved word, the illegal-state bit is raised, and the program counter still takes the saved address unchanged.

Top module: `xret_legality`

## Requirements
- R1: `done_o` pulses high exactly one cycle after each cycle with `req_i` high and is low otherwise. The other outputs update only on that cycle and reset to zero.
- R2: With saved bit 4 clear (wide request), the return is illegal if saved bit 1 is set or saved bits 3:0 equal 4'b0001. Otherwise the target level is saved bits 3:2.
- R3: With saved bit 4 set (narrow request), mode bits 4:0 decode as follows: 0x10 gives level 0 and 0x1A gives level 2. The values 0x11, 0x12, 0x13, 0x17, 0x1B and 0x1F give level 1. Any other value, including 0x16, is illegal.
- R4: A target level above `cur_lvl_i` is illegal. A target of level 2 with `lvl2_impl_i` low is illegal.
- R5: A nonzero target level is illegal when `wide_lvl_i[target]` differs from the inverse of saved bit 4.
- R6: A target of level 2 is illegal when `secure_i` is high and `cur_lvl_i` is not 3.
- R7: A target of level 1 is illegal when `tge_i` is high, unless `secure_i` is high and `cur_lvl_i` is not 3.
- R8: A legal return outputs `legal_o`=1 and the decoded level on `tgt_lvl_o`. The status word is the saved word. For a wide request the program counter is `ret_addr_i`.
- R9: A legal narrow return clears address bit 0 if saved bit 5 is set, and clears bits 1:0 if it is clear.
- R10: An illegal return outputs `legal_o`=0, `tgt_lvl_o`=`cur_lvl_i` and `pc_o`=`ret_addr_i`. The status word is `cur_psw_i` with bits 31:28 and 9:6 taken from the saved word and bit 20 set.
- R11: Output status bit 21 is forced to 0 unless `ss_active_i` is high, in which case it keeps its source value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Evaluate-return strobe |
| psw_i | input | 32 | Saved status word |
| cur_psw_i | input | 32 | Current status word |
| cur_lvl_i | input | 2 | Current exception level |
| ret_addr_i | input | ADDR_W | Saved return address |
| lvl2_impl_i | input | 1 | Level 2 is implemented |
| wide_lvl_i | input | 4 | Per-level wide register width flag |
| secure_i | input | 1 | Secure state |
| tge_i | input | 1 | Trap-general-exceptions control |
| ss_active_i | input | 1 | Single-step active at target |
| done_o | output | 1 | Result valid pulse |
| legal_o | output | 1 | Return is legal |
| tgt_lvl_o | output | 2 | Resulting exception level |
| pc_o | output | ADDR_W | Resulting program counter |
| psw_o | output | 32 | Resulting status word |

## Verification
Directed cases reach each legality rule in isolation: reserved wide encodings, the monitor and unknown narrow modes, a target above the current level, an unimplemented level 2, a width mismatch, the secure level-2 case and the trap control. Each case shows that a rule fires on its own condition and not on a neighbour's. Narrow returns are tried with the compact-set flag both set and clear, using odd addresses so the two alignment masks give different results. Seeded random requests mix valid narrow mode codes with arbitrary words and configurations. These exercise the rule ordering, the partial restore and the single-step masking against a bench model.

// File: rtl/xret_pkg.sv
package xret_pkg;
  localparam int PSW_W   = 32;
  localparam int LVL_W   = 2;
  localparam int N_LVL   = 1 << LVL_W;
  localparam int NRW_BIT = 4;
  localparam int CMP_BIT = 5;
  localparam int IL_BIT  = 20;
  localparam int SS_BIT  = 21;
  localparam int MSK_LO  = 6;
  localparam int MSK_HI  = 9;
  localparam int FLG_LO  = 28;
  localparam int FLG_HI  = 31;

  typedef enum logic [4:0] {
    M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12, M_SVC = 5'h13,
    M_MON = 5'h16, M_ABT = 5'h17, M_HYP = 5'h1A, M_UND = 5'h1B,
    M_SYS = 5'h1F
  } nmode_e;

  localparam logic [PSW_W-1:0] KEEP_MASK =
    (PSW_W'((1 << (FLG_HI - FLG_LO + 1)) - 1) << FLG_LO) |
    (PSW_W'((1 << (MSK_HI - MSK_LO + 1)) - 1) << MSK_LO);
endpackage

// File: rtl/xret_mode_dec.sv
module xret_mode_dec
  import xret_pkg::*;
(
  input  logic [PSW_W-1:0] psw_i,
  output logic             valid_o,
  output logic [LVL_W-1:0] lvl_o
);
  always_comb begin
    valid_o = 1'b1;
    lvl_o   = '0;
    if (psw_i[NRW_BIT]) begin
      unique case (psw_i[4:0])
        M_USR:                                lvl_o = 2'd0;
        M_HYP:                                lvl_o = 2'd2;
        M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: lvl_o = 2'd1;
        default:                              valid_o = 1'b0;
      endcase
    end else begin
      lvl_o = psw_i[3:2];
      if (psw_i[1] || psw_i[3:0] == 4'b0001) valid_o = 1'b0;
    end
  end
endmodule

// File: rtl/xret_rules.sv
module xret_rules
  import xret_pkg::*;
(
  input  logic             valid_i,
  input  logic [LVL_W-1:0] tgt_i,
  input  logic             nrw_i,
  input  logic [LVL_W-1:0] cur_lvl_i,
  input  logic             lvl2_impl_i,
  input  logic [N_LVL-1:0] wide_lvl_i,
  input  logic             secure_i,
  input  logic             tge_i,
  output logic             legal_o
);
  logic sec_low, too_high, no_l2, width_bad, sec_l2, tge_l1;

  always_comb begin
    sec_low   = secure_i && (cur_lvl_i != 2'd3);
    too_high  = tgt_i > cur_lvl_i;
    no_l2     = (tgt_i == 2'd2) && !lvl2_impl_i;
    width_bad = (tgt_i != '0) && (wide_lvl_i[tgt_i] == nrw_i);
    sec_l2    = (tgt_i == 2'd2) && sec_low;
    tge_l1    = (tgt_i == 2'd1) && tge_i && !sec_low;
    legal_o   = valid_i && !too_high && !no_l2 && !width_bad && !sec_l2 && !tge_l1;
  end
endmodule

// File: rtl/xret_form.sv
module xret_form
  import xret_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              legal_i,
  input  logic [LVL_W-1:0]  tgt_i,
  input  logic [PSW_W-1:0]  psw_i,
  input  logic [PSW_W-1:0]  cur_psw_i,
  input  logic [LVL_W-1:0]  cur_lvl_i,
  input  logic [ADDR_W-1:0] ret_addr_i,
  input  logic              ss_active_i,
  output logic [LVL_W-1:0]  lvl_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [PSW_W-1:0]  psw_o
);
  logic [ADDR_W-1:0] align_mask;
  logic [PSW_W-1:0]  psw_pre;

  always_comb begin
    align_mask = '1;
    if (psw_i[NRW_BIT]) align_mask[1:0] = psw_i[CMP_BIT] ? 2'b10 : 2'b00;
    if (legal_i) begin
      lvl_o   = tgt_i;
      pc_o    = ret_addr_i & align_mask;
      psw_pre = psw_i;
    end else begin
      lvl_o   = cur_lvl_i;
      pc_o    = ret_addr_i;
      psw_pre = (psw_i & KEEP_MASK) | (cur_psw_i & ~KEEP_MASK);
      psw_pre[IL_BIT] = 1'b1;
    end
    psw_o = psw_pre;
    if (!ss_active_i) psw_o[SS_BIT] = 1'b0;
  end
endmodule

// File: rtl/xret_legality.sv
module xret_legality
  import xret_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [31:0]       psw_i,
  input  logic [31:0]       cur_psw_i,
  input  logic [1:0]        cur_lvl_i,
  input  logic [ADDR_W-1:0] ret_addr_i,
  input  logic              lvl2_impl_i,
  input  logic [3:0]        wide_lvl_i,
  input  logic              secure_i,
  input  logic              tge_i,
  input  logic              ss_active_i,
  output logic              done_o,
  output logic              legal_o,
  output logic [1:0]        tgt_lvl_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [31:0]       psw_o
);
  logic              dec_valid, legal_c;
  logic [LVL_W-1:0]  dec_lvl, lvl_c;
  logic [ADDR_W-1:0] pc_c;
  logic [PSW_W-1:0]  psw_c;

  xret_mode_dec u_dec (
    .psw_i  (psw_i),
    .valid_o(dec_valid),
    .lvl_o  (dec_lvl)
  );

  xret_rules u_rules (
    .valid_i    (dec_valid),
    .tgt_i      (dec_lvl),
    .nrw_i      (psw_i[NRW_BIT]),
    .cur_lvl_i  (cur_lvl_i),
    .lvl2_impl_i(lvl2_impl_i),
    .wide_lvl_i (wide_lvl_i),
    .secure_i   (secure_i),
    .tge_i      (tge_i),
    .legal_o    (legal_c)
  );

  xret_form #(.ADDR_W(ADDR_W)) u_form (
    .legal_i    (legal_c),
    .tgt_i      (dec_lvl),
    .psw_i      (psw_i),
    .cur_psw_i  (cur_psw_i),
    .cur_lvl_i  (cur_lvl_i),
    .ret_addr_i (ret_addr_i),
    .ss_active_i(ss_active_i),
    .lvl_o      (lvl_c),
    .pc_o       (pc_c),
    .psw_o      (psw_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      legal_o   <= 1'b0;
      tgt_lvl_o <= '0;
      pc_o      <= '0;
      psw_o     <= '0;
    end else begin
      done_o <= req_i;
      if (req_i) begin
        legal_o   <= legal_c;
        tgt_lvl_o <= lvl_c;
        pc_o      <= pc_c;
        psw_o     <= psw_c;
      end
    end
  end
endmodule

// File: rtl/xret_legality_chk.sv
module xret_legality_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [31:0]       psw_i,
  input logic [1:0]        cur_lvl_i,
  input logic [ADDR_W-1:0] ret_addr_i,
  input logic              secure_i,
  input logic              tge_i,
  input logic              ss_active_i,
  input logic              done_o,
  input logic              legal_o,
  input logic [1:0]        tgt_lvl_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [31:0]       psw_o
);
  // R1
  done_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);
  // R1
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !done_o);
  // R4
  no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (!legal_o || tgt_lvl_o <= $past(cur_lvl_i)));
  // R10
  illegal_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (legal_o || (tgt_lvl_o == $past(cur_lvl_i) && psw_o[20]
                           && pc_o == $past(ret_addr_i))));
  // R11
  ss_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ss_active_i) |=> !psw_o[21]);
  // R7
  tge_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && tge_i && !(secure_i && cur_lvl_i != 2'd3)) |=> !(legal_o && tgt_lvl_o == 2'd1));
  // R2
  wide_rsv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !psw_i[4] && psw_i[1]) |=> !legal_o);
endmodule

bind xret_legality xret_legality_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .psw_i      (psw_i),
  .cur_lvl_i  (cur_lvl_i),
  .ret_addr_i (ret_addr_i),
  .secure_i   (secure_i),
  .tge_i      (tge_i),
  .ss_active_i(ss_active_i),
  .done_o     (done_o),
  .legal_o    (legal_o),
  .tgt_lvl_o  (tgt_lvl_o),
  .pc_o       (pc_o),
  .psw_o      (psw_o)
);

// File: tb/tb_xret_legality.sv
module tb_xret_legality;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 64;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic [31:0]       psw_i = '0;
  logic [31:0]       cur_psw_i = '0;
  logic [1:0]        cur_lvl_i = '0;
  logic [ADDR_W-1:0] ret_addr_i = '0;
  logic              lvl2_impl_i = 1'b0;
  logic [3:0]        wide_lvl_i = '0;
  logic              secure_i = 1'b0;
  logic              tge_i = 1'b0;
  logic              ss_active_i = 1'b0;
  logic              done_o, legal_o;
  logic [1:0]        tgt_lvl_o;
  logic [ADDR_W-1:0] pc_o;
  logic [31:0]       psw_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xret_legality #(.ADDR_W(ADDR_W)) dut (.*);

  task automatic check(input string tag, input bit ok, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic ref_model(output bit lg, output logic [1:0] lv,
                           output logic [ADDR_W-1:0] pc, output logic [31:0] pw,
                           output string tag);
    bit ok = 1'b1;
    logic [1:0] t = 2'd0;
    bit nar = psw_i[4];
    bit slow = secure_i && cur_lvl_i != 2'd3;
    tag = "";
    if (nar) begin
      case (psw_i[4:0])
        5'h10: t = 0;
        5'h1A: t = 2;
        5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F: t = 1;
        default: begin ok = 0; tag = "R3"; end
      endcase
    end else begin
      t = psw_i[3:2];
      if (psw_i[1] || psw_i[3:0] == 4'd1) begin ok = 0; tag = "R2"; end
    end
    if (ok && (t > cur_lvl_i || (t == 2 && !lvl2_impl_i))) begin ok = 0; tag = "R4"; end
    if (ok && t != 0 && wide_lvl_i[t] != !nar) begin ok = 0; tag = "R5"; end
    if (ok && t == 2 && slow) begin ok = 0; tag = "R6"; end
    if (ok && t == 1 && tge_i && !slow) begin ok = 0; tag = "R7"; end
    lg = ok;
    if (ok) begin
      lv = t;
      pw = psw_i;
      pc = ret_addr_i;
      if (nar) pc = psw_i[5] ? {ret_addr_i[ADDR_W-1:1], 1'b0} : {ret_addr_i[ADDR_W-1:2], 2'b00};
      tag = nar ? "R9" : "R8";
    end else begin
      lv = cur_lvl_i;
      pc = ret_addr_i;
      pw = cur_psw_i;
      pw[31:28] = psw_i[31:28];
      pw[9:6] = psw_i[9:6];
      pw[20] = 1'b1;
      tag = {tag, "/R10"};
    end
    if (!ss_active_i) pw[21] = 1'b0;
  endtask

  task automatic run(input string dtag);
    bit lg; logic [1:0] lv; logic [ADDR_W-1:0] pc; logic [31:0] pw; string tg;
    ref_model(lg, lv, pc, pw, tg);
    if (dtag != "") tg = dtag;
    if (psw_i[21]) tg = {tg, "/R11"};
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    check({tg, "/R1"}, done_o == 1'b1 && legal_o == lg && tgt_lvl_o == lv && pc_o == pc && psw_o == pw,
          $sformatf("done=%0b legal=%0b lvl=%0d pc=%h psw=%h", done_o, legal_o, tgt_lvl_o, pc_o, psw_o),
          $sformatf("done=1 legal=%0b lvl=%0d pc=%h psw=%h", lg, lv, pc, pw));
    @(negedge clk_i);
  endtask

  task automatic setup(input logic [31:0] p, input logic [1:0] cl, input logic l2,
                       input logic [3:0] w, input logic s, input logic g, input logic ss);
    psw_i = p; cur_lvl_i = cl; lvl2_impl_i = l2; wide_lvl_i = w;
    secure_i = s; tge_i = g; ss_active_i = ss;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [4:0] modes [9];
    modes = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1F};
    void'($urandom(32'd1234));
    cur_psw_i = 32'h0A5A_3C0F;
    ret_addr_i = 64'h0000_1234_5678_9ABF;
    repeat (3) @(negedge clk_i);
    check("R1 reset", done_o == 0 && legal_o == 0 && tgt_lvl_o == 0 && pc_o == 0 && psw_o == 0,
          $sformatf("done=%0b legal=%0b pc=%h psw=%h", done_o, legal_o, pc_o, psw_o), "all zero");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle", done_o == 0, $sformatf("%0b", done_o), "0");

    setup(32'hF000_03C5, 2'd1, 1, 4'b1110, 0, 0, 0); run("R8");
    setup(32'h0000_0006, 2'd3, 1, 4'b1110, 0, 0, 0); run("R2");
    setup(32'h0000_0001, 2'd3, 1, 4'b1110, 0, 0, 0); run("R2");
    setup(32'h0000_001A, 2'd2, 1, 4'b1000, 0, 0, 0); run("R3");
    setup(32'h0000_0016, 2'd3, 1, 4'b0000, 0, 0, 0); run("R3");
    setup(32'h0000_0009, 2'd1, 1, 4'b1110, 0, 0, 0); run("R4");
    setup(32'h0000_0009, 2'd3, 0, 4'b1110, 0, 0, 0); run("R4");
    setup(32'h0000_0010, 2'd1, 1, 4'b1110, 0, 0, 0); run("R5");
    setup(32'h0000_0013, 2'd1, 1, 4'b1110, 0, 0, 0); run("R5");
    setup(32'h0000_0009, 2'd2, 1, 4'b1110, 1, 0, 0); run("R6");
    setup(32'h0000_0005, 2'd2, 1, 4'b1110, 0, 1, 0); run("R7");
    setup(32'h0000_0005, 2'd1, 1, 4'b1110, 1, 1, 0); run("R7");
    setup(32'h0000_0033, 2'd1, 1, 4'b0000, 0, 0, 0); run("R9");
    setup(32'h0000_0013, 2'd1, 1, 4'b0000, 0, 0, 0); run("R9");
    setup(32'hA020_0245, 2'd1, 1, 4'b1110, 0, 0, 1); run("R11");
    setup(32'hA020_0245, 2'd1, 1, 4'b1110, 0, 0, 0); run("R11");
    setup(32'h5020_0006, 2'd1, 1, 4'b1110, 0, 0, 1); run("R10");
    check("R1 quiet", done_o == 0, $sformatf("%0b", done_o), "0");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] p = $urandom();
      if ($urandom_range(0, 1) == 1) p[4:0] = modes[$urandom_range(0, 8)];
      setup(p, 2'($urandom()), 1'($urandom()), 4'($urandom()), 1'($urandom()),
            1'($urandom()), 1'($urandom()));
      cur_psw_i = $urandom();
      ret_addr_i = {$urandom(), $urandom()};
      run("");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule